// File: doc/BRIEF.md
# Hierarchical Statechart Step Engine

This block runs a flattened hierarchical statechart in hardware. It takes one microstep on every clock in which `en` is high. The set of active states is kept as a vector with one bit per state, and several bits may be set at once: ancestors, orthogonal regions and leaves all have their own bits. The chart is given entirely by constant parameter bit-matrices. Each transition has a one-hot source, an exit mask, a target mask, an eventless flag and an event-match mask. Each state has a one-hot parent and flags that mark it as compound, parallel, default child or top-level final. States are numbered so that every parent has a lower index than its children. Transitions are numbered in postfix document order.

Events arrive on a valid/ready port and wait in an internal queue until the engine is free to consume them. An event is accepted on a clock edge where `ev_valid` and `ev_ready` are both high. `ev_ready` is low exactly while the queue is full. While it is low the offered event is not taken, so the producer must hold `ev_code` and `ev_valid` until it sees ready. Event-name prefix matching and the wildcard are resolved when the match masks are built: a descriptor sets one mask bit for every event code it covers.

The default parameters describe a small example chart, which the requirements use:
- State bits: 0 run (compound, parent of 1 and 2), 1 idle (default child of run), 2 busy (parallel, parent of 3 and 6), 3 ra (compound, children 4 and 5), 4 a1 (default), 5 a2, 6 rb (compound, children 7 and 8), 7 b1 (default), 8 b2, 9 done (top-level final).
- Initial state: run.
- Event codes: 0 go, 1 go.fast, 2 stop, 3 tick.
- Transitions, from highest to lowest priority:
  - T0: a1 goes to a2 on tick.
  - T1: a2 goes to a1 on any event.
  - T2: b1 goes to b2 on tick.
  - T3: b2 goes to b1 with no event.
  - T4: busy goes to idle on stop.
  - T5: idle goes to done on stop.
  - T6: run goes to busy on go or go.fast.

Top module: `sc_engine`

## Requirements
- R1: While reset is asserted, `active_o` is all zero and `complete_o` and `err_o` are low. Once reset is released, the first enabled cycle fills the configuration.
- R2: The first enabled cycle after reset enters the initial state and its default descendants through the normal entry logic. In the example chart this gives `active_o` = 0x003.
- R3: Stall is the inverse of `en`. While `en` is low the configuration holds and no event leaves the queue, and a queued event is still processed once `en` returns.
- R4: A transition is a candidate only when its source bit is active and the head event's code has its bit set in the transition's match mask. go.fast (code 1) fires the transition on prefix go. An event that matches no candidate is consumed and leaves the configuration unchanged.
- R5: Candidates are granted in ascending index. A candidate is blocked when a lower-indexed transition that is already granted has its bit set in the candidate's conflict row. In the example, stop in a2 takes T1 (the wildcard), which blocks T4, so the result is 0x0DD.
- R6: Transitions that do not conflict fire in the same step. In the example, tick in {a1, b1} moves both regions and gives 0x16D.
- R7: When any eventless transition has an active source, only eventless transitions are considered and the queue is not read. A queued event waits for that step, so 0x16D becomes 0x0ED while stop stays queued.
- R8: A state's next value is (active AND NOT exiting) OR entering. A state exits when it is active and set in the exit mask of a granted transition. The entry set holds the targets and their ancestors, every child of an entered parallel state, and the default child of an entered compound state when no other child of that state remains active or is being entered. In the example, go from idle gives 0x0DD and stop from busy gives 0x003.
- R9: The queue holds DEPTH events. `ev_ready` drops when the queue is full, and an event offered while the queue is full is never stored.
- R10: `err_o` is a register that samples the queue-full condition on every clock. It goes high one cycle after the queue fills and low one cycle after the queue stops being full.
- R11: `complete_o` is high whenever a top-level final state is active. In the example, stop in idle gives 0x200 with `complete_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Step enable; low means stall |
| ev_valid | input | 1 | Event offer valid |
| ev_ready | output | 1 | Queue can accept an event |
| ev_code | input | EVW | Event code offered |
| active_o | output | NS | Active-state vector |
| complete_o | output | 1 | A top-level final state is active |
| err_o | output | 1 | Registered queue-full indication |

## Verification
A wrong exit or entry term shows up on `active_o` at the sampling point right after the enabled edge. Typical symptoms are a missing default child, a parallel region left empty, or an ancestor dropped. A priority or conflict fault shows up as the wrong region moving on the same edge. A fault in phase ordering or event consumption shows up one step later, as an event that was applied too early, lost or applied twice. The stimulus therefore checks the configuration after every single step, and it chains steps so that a consumption fault changes a later result.

// File: rtl/sc_chart_pkg.sv
package sc_chart_pkg;
  // Example chart used as default parameterisation.
  localparam int DEF_NS  = 10;
  localparam int DEF_NT  = 7;
  localparam int DEF_NEV = 4;

  // Per transition, index NT-1 first.
  localparam logic [DEF_NT-1:0][DEF_NS-1:0] DEF_SRC =
    {10'h001, 10'h002, 10'h004, 10'h100, 10'h080, 10'h020, 10'h010};
  localparam logic [DEF_NT-1:0][DEF_NS-1:0] DEF_EXIT =
    {10'h1FE, 10'h1FF, 10'h1FC, 10'h100, 10'h080, 10'h020, 10'h010};
  localparam logic [DEF_NT-1:0][DEF_NS-1:0] DEF_TGT =
    {10'h004, 10'h200, 10'h002, 10'h080, 10'h100, 10'h010, 10'h020};
  localparam logic [DEF_NT-1:0] DEF_EVENTLESS = 7'b0001000;
  localparam logic [DEF_NT-1:0][DEF_NEV-1:0] DEF_MATCH =
    {4'h3, 4'h4, 4'h4, 4'h0, 4'h8, 4'hF, 4'h8};
  localparam logic [DEF_NT-1:0][DEF_NT-1:0] DEF_CONFLICT =
    {7'h3F, 7'h5F, 7'h6F, 7'h70, 7'h70, 7'h70, 7'h70};

  // Per state, index NS-1 first: one-hot parent, zero for top level.
  localparam logic [DEF_NS-1:0][DEF_NS-1:0] DEF_PARENT =
    {10'h000, 10'h040, 10'h040, 10'h004, 10'h008,
     10'h008, 10'h004, 10'h001, 10'h001, 10'h000};
  localparam logic [DEF_NS-1:0] DEF_COMPOUND  = 10'h049;
  localparam logic [DEF_NS-1:0] DEF_PARALLEL  = 10'h004;
  localparam logic [DEF_NS-1:0] DEF_DEFAULT   = 10'h092;
  localparam logic [DEF_NS-1:0] DEF_TOP_FINAL = 10'h200;
  localparam logic [DEF_NS-1:0] DEF_INIT      = 10'h001;
endpackage

// File: rtl/sc_event_queue.sv
module sc_event_queue #(
  parameter int DEPTH = 4,
  parameter int EVW   = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [EVW-1:0] in_code,
  input  logic           pop,
  output logic           empty,
  output logic           full,
  output logic [EVW-1:0] head
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [EVW-1:0] mem [DEPTH];
  logic [AW-1:0]  wr_ptr, rd_ptr;
  logic [CW-1:0]  count;
  logic           push, do_pop;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign in_ready = !full;
  assign push     = in_valid && !full;
  assign do_pop   = pop && !empty;
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)   wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(do_pop);
    end
  end

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r9_full_blocks_store: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full && $stable(wr_ptr));
endmodule

// File: rtl/sc_select.sv
module sc_select #(
  parameter int NS  = 10,
  parameter int NT  = 7,
  parameter int NEV = 4,
  parameter int EVW = 2,
  parameter logic [NT-1:0][NS-1:0]  SRC       = '0,
  parameter logic [NT-1:0]          EVENTLESS = '0,
  parameter logic [NT-1:0][NEV-1:0] MATCH     = '0,
  parameter logic [NT-1:0][NT-1:0]  CONFLICT  = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NS-1:0]  active,
  input  logic           run_ok,
  input  logic           q_empty,
  input  logic [EVW-1:0] ev_code,
  output logic           take,
  output logic [NT-1:0]  sel
);
  logic [NT-1:0] src_on, cand;
  logic          spont_en;

  always_comb begin
    for (int t = 0; t < NT; t++) src_on[t] = |(SRC[t] & active);
    spont_en = |(src_on & EVENTLESS);
    take     = run_ok && !spont_en && !q_empty;
    for (int t = 0; t < NT; t++)
      cand[t] = src_on[t] && (spont_en ? EVENTLESS[t]
                                       : (!EVENTLESS[t] && take && MATCH[t][ev_code]));
  end

  // Priority walk: earlier grants block later conflicting candidates.
  always_comb begin
    logic [NT-1:0] g;
    g = '0;
    for (int t = 0; t < NT; t++)
      g[t] = cand[t] && !(|(g & CONFLICT[t]));
    sel = g;
  end

  for (genvar t = 0; t < NT; t++) begin : g_chk
    a_r5_conflict_free: assert property (@(posedge clk) disable iff (!rst_n)
      sel[t] |-> !(|(sel & CONFLICT[t])));
    a_r7_phase_split: assert property (@(posedge clk) disable iff (!rst_n)
      (sel[t] && take) |-> !EVENTLESS[t]);
  end
endmodule

// File: rtl/sc_config.sv
module sc_config #(
  parameter int NS = 10,
  parameter int NT = 7,
  parameter logic [NT-1:0][NS-1:0] EXIT     = '0,
  parameter logic [NT-1:0][NS-1:0] TGT      = '0,
  parameter logic [NS-1:0][NS-1:0] PARENT   = '0,
  parameter logic [NS-1:0]         COMPOUND = '0,
  parameter logic [NS-1:0]         PARALLEL = '0,
  parameter logic [NS-1:0]         DEFAULT  = '0,
  parameter logic [NS-1:0]         INIT     = '0
) (
  input  logic [NS-1:0] active,
  input  logic [NT-1:0] sel,
  input  logic          run_ok,
  output logic [NS-1:0] next_active
);
  always_comb begin
    logic [NS-1:0] ex, tg, up, stay, occ, ent;
    ex = '0;
    tg = '0;
    for (int t = 0; t < NT; t++)
      if (sel[t]) begin
        ex = ex | EXIT[t];
        tg = tg | TGT[t];
      end
    ex = ex & active;
    if (!run_ok) tg = INIT;
    // Upward: targets pull in their ancestors (children have higher indices).
    up = tg;
    for (int s = NS - 1; s >= 0; s--)
      for (int p = 0; p < NS; p++)
        if (PARENT[s][p] && up[s]) up[p] = 1'b1;
    // Which parents keep or gain a child.
    stay = (active & ~ex) | up;
    occ  = '0;
    for (int s = 0; s < NS; s++)
      for (int p = 0; p < NS; p++)
        if (PARENT[s][p] && stay[s]) occ[p] = 1'b1;
    // Downward: parallel children and default completion.
    ent = up;
    for (int s = 0; s < NS; s++)
      for (int p = 0; p < NS; p++)
        if (PARENT[s][p] && ent[p] &&
            (PARALLEL[p] || (COMPOUND[p] && DEFAULT[s] && !occ[p])))
          ent[s] = 1'b1;
    next_active = (active & ~ex) | ent;
  end
endmodule

// File: rtl/sc_engine.sv
module sc_engine
  import sc_chart_pkg::*;
#(
  parameter int NS    = DEF_NS,
  parameter int NT    = DEF_NT,
  parameter int NEV   = DEF_NEV,
  parameter int DEPTH = 4,
  parameter logic [NT-1:0][NS-1:0]  SRC       = DEF_SRC,
  parameter logic [NT-1:0][NS-1:0]  EXIT      = DEF_EXIT,
  parameter logic [NT-1:0][NS-1:0]  TGT       = DEF_TGT,
  parameter logic [NT-1:0]          EVENTLESS = DEF_EVENTLESS,
  parameter logic [NT-1:0][NEV-1:0] MATCH     = DEF_MATCH,
  parameter logic [NT-1:0][NT-1:0]  CONFLICT  = DEF_CONFLICT,
  parameter logic [NS-1:0][NS-1:0]  PARENT    = DEF_PARENT,
  parameter logic [NS-1:0]          COMPOUND  = DEF_COMPOUND,
  parameter logic [NS-1:0]          PARALLEL  = DEF_PARALLEL,
  parameter logic [NS-1:0]          DEFAULT   = DEF_DEFAULT,
  parameter logic [NS-1:0]          TOP_FINAL = DEF_TOP_FINAL,
  parameter logic [NS-1:0]          INIT      = DEF_INIT,
  localparam int EVW = (NEV > 1) ? $clog2(NEV) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           ev_valid,
  output logic           ev_ready,
  input  logic [EVW-1:0] ev_code,
  output logic [NS-1:0]  active_o,
  output logic           complete_o,
  output logic           err_o
);
  logic [NS-1:0]  active_q, next_active;
  logic [NT-1:0]  sel;
  logic [EVW-1:0] head;
  logic           booted, q_empty, q_full, take, run_ok;

  assign run_ok = booted;

  sc_event_queue #(.DEPTH(DEPTH), .EVW(EVW)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .in_valid(ev_valid), .in_ready(ev_ready), .in_code(ev_code),
    .pop(take && en), .empty(q_empty), .full(q_full), .head(head)
  );

  sc_select #(
    .NS(NS), .NT(NT), .NEV(NEV), .EVW(EVW),
    .SRC(SRC), .EVENTLESS(EVENTLESS), .MATCH(MATCH), .CONFLICT(CONFLICT)
  ) u_select (
    .clk(clk), .rst_n(rst_n),
    .active(active_q), .run_ok(run_ok), .q_empty(q_empty), .ev_code(head),
    .take(take), .sel(sel)
  );

  sc_config #(
    .NS(NS), .NT(NT), .EXIT(EXIT), .TGT(TGT), .PARENT(PARENT),
    .COMPOUND(COMPOUND), .PARALLEL(PARALLEL), .DEFAULT(DEFAULT), .INIT(INIT)
  ) u_config (
    .active(active_q), .sel(sel), .run_ok(run_ok), .next_active(next_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
      booted   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      err_o <= q_full;
      if (en) begin
        active_q <= next_active;
        booted   <= 1'b1;
      end
    end
  end

  assign active_o   = active_q;
  assign complete_o = |(active_q & TOP_FINAL);

  a_r3_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(active_q));
  a_r10_err_tracks_full: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |=> err_o);
  a_r8_quiet_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && booted && !(|sel)) |=> $stable(active_q));
  for (genvar s = 0; s < NS; s++) begin : g_tree
    if (PARENT[s] != '0) begin : g_has_parent
      a_r8_parent_active: assert property (@(posedge clk) disable iff (!rst_n)
        active_q[s] |-> |(active_q & PARENT[s]));
    end
  end
endmodule

// File: tb/test_sc_engine.sv
module test_sc_engine;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       ev_valid = 1'b0;
  logic       ev_ready;
  logic [1:0] ev_code = '0;
  logic [9:0] active_o;
  logic       complete_o, err_o;

  int tests = 0;
  int fails = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sc_engine i_sc_engine (
    .clk(clk), .rst_n(rst_n), .en(en), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_code(ev_code), .active_o(active_o), .complete_o(complete_o), .err_o(err_o)
  );

  typedef struct packed {
    logic       push;
    logic [1:0] code;
    logic [9:0] exp_act;
    logic       exp_done;
    logic [3:0] req;
  } vec_t;

  // codes: 0 go, 1 go.fast, 2 stop, 3 tick
  localparam vec_t VECS [11] = '{
    '{1'b0, 2'd0, 10'h003, 1'b0, 4'd2},   // R2 boot
    '{1'b1, 2'd0, 10'h0DD, 1'b0, 4'd8},   // R8 go enters busy with defaults
    '{1'b1, 2'd3, 10'h16D, 1'b0, 4'd6},   // R6 both regions move
    '{1'b0, 2'd0, 10'h0ED, 1'b0, 4'd7},   // R7 eventless b2->b1
    '{1'b1, 2'd2, 10'h0DD, 1'b0, 4'd5},   // R5 wildcard beats stop
    '{1'b1, 2'd2, 10'h003, 1'b0, 4'd8},   // R8 busy exits to idle
    '{1'b1, 2'd1, 10'h0DD, 1'b0, 4'd4},   // R4 prefix match
    '{1'b1, 2'd2, 10'h003, 1'b0, 4'd5},   // R5
    '{1'b1, 2'd3, 10'h003, 1'b0, 4'd4},   // R4 unmatched consumed
    '{1'b0, 2'd0, 10'h003, 1'b0, 4'd4},   // R4 nothing left queued
    '{1'b1, 2'd2, 10'h200, 1'b1, 4'd11}   // R11 final reached
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] c);
    ev_valid = 1'b1;
    ev_code  = c;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic step(input int n);
    en = 1'b1;
    repeat (n) @(negedge clk);
    en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done_flag) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(1, active_o, 10'h000);
    chk(1, complete_o, 1'b0);
    chk(1, err_o, 1'b0);
    chk(9, ev_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(1, active_o, 10'h000);

    foreach (VECS[i]) begin
      if (VECS[i].push) push(VECS[i].code);
      step(1);
      chk(int'(VECS[i].req), active_o, VECS[i].exp_act);
      chk(int'(VECS[i].req), complete_o, VECS[i].exp_done);
    end

    // R1 reset clears everything
    do_reset();
    chk(1, active_o, 10'h000);
    chk(11, complete_o, 1'b0);

    // R3 stall: queued event waits while en is low
    step(1);
    chk(2, active_o, 10'h003);
    push(2'd0);
    repeat (5) @(negedge clk);
    chk(3, active_o, 10'h003);
    step(1);
    chk(3, active_o, 10'h0DD);

    // R7 eventless step holds back a queued event
    push(2'd3);
    push(2'd2);
    step(1);
    chk(6, active_o, 10'h16D);
    step(1);
    chk(7, active_o, 10'h0ED);
    step(1);
    chk(5, active_o, 10'h0DD);

    // R9 / R10 queue full
    do_reset();
    step(1);
    push(2'd0);
    push(2'd3);
    push(2'd2);
    push(2'd2);
    chk(9, ev_ready, 1'b0);
    @(negedge clk);
    chk(10, err_o, 1'b1);
    push(2'd2);                  // offered while full: not stored
    step(1);
    chk(9, active_o, 10'h0DD);
    step(1);
    chk(9, active_o, 10'h16D);
    chk(10, err_o, 1'b0);
    step(1);
    chk(7, active_o, 10'h0ED);
    step(1);
    chk(5, active_o, 10'h0DD);
    step(1);
    chk(8, active_o, 10'h003);
    step(1);
    chk(9, active_o, 10'h003);   // dropped stop never arrives
    chk(9, ev_ready, 1'b1);

    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule